// File: doc/BRIEF.md
# Raster Sync Timing Generator

This block walks a fixed raster of 1024 clock positions per line and 312 lines per frame. It drives an active-low horizontal sync and an active-low vertical sync, and it presents the current column and line counts. It also raises two window flags. One marks the visible pixel area. The other marks a fetch area that opens eight positions before the visible one, so downstream logic has time to read pixel data.

A single-cycle line-step pulse fires at the start of each line that lies strictly inside the visible band. An address generator can use it to advance. The block produces no pixels, makes no memory accesses and generates no colour. It only reports where the raster is and when sync is due.

Top module: `raster_timing`

## Requirements
- R1: While reset is asserted and in the first cycle after it, xPos and yPos are 0, hsyncN and vsyncN are 1, and lineStep is 0.
- R2: xPos advances by one each clock from 0 to 1023. Leaving 1023 it returns to 0 and yPos advances by one.
- R3: Leaving position 1023 of line 311, both xPos and yPos return to 0.
- R4: hsyncN is 0 exactly when xPos is between 1 and 75 inclusive. The low edge follows position 0 and the high edge follows position 75, both one clock later.
- R5: vsyncN is 0 in three places: on line 0 for xPos of 1 or more, on all of line 1, and on line 2 for xPos up to and including 512. It rises one clock after position 512 of line 2, halfway through that line.
- R6: pixelActive is 1 exactly when yPos is in 38..293 and xPos is in 264..903, which is 256 lines by 640 positions.
- R7: prefetchActive is 1 exactly when yPos is in 38..293 and xPos is in 256..895, which leads the visible span by 8 positions.
- R8: lineStep is 1 for the single cycle at xPos 0 of lines 39..293. It stays 0 at line 38 and on every line outside the visible band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one raster position per cycle |
| rst | input | 1 | Synchronous reset, active high |
| hsyncN | output | 1 | Horizontal sync, active low |
| vsyncN | output | 1 | Vertical sync, active low |
| xPos | output | 10 | Current position within the line |
| yPos | output | 9 | Current line within the frame |
| pixelActive | output | 1 | Inside the visible window |
| prefetchActive | output | 1 | Inside the fetch window |
| lineStep | output | 1 | One-cycle pulse at the start of an inner visible line |

## Verification
The bench runs the full-size generator through its first forty lines. It compares every cycle against a position model and checks hand-computed points at each sync edge and at each window boundary. The points one position before and one after each edge catch off-by-one compares and a wrong sync lag. A reduced-size instance runs through many frames so the frame wrap and the bottom edge of the visible band are covered. Its checks on the first and last visible lines separate a strict-inside line-step condition from an inclusive one. A reset applied mid-frame shows the counters and syncs return to their idle state from an arbitrary position.

// File: rtl/raster_pkg.sv
package raster_pkg;
  // Events decoded from the current raster position, consumed by the datapath.
  typedef struct packed {
    logic endOfLine;
    logic endOfFrame;
    logic hsFall;
    logic hsRise;
    logic vsFall;
    logic vsRise;
    logic stepNext;
  } rasterStrobes_t;
endpackage

// File: rtl/raster_ctrl.sv
module raster_ctrl
  import raster_pkg::*;
#(
  parameter int LINE_LEN       = 1024,
  parameter int FRAME_LINES    = 312,
  parameter int HSYNC_END      = 75,
  parameter int VSYNC_END_LINE = 2,
  parameter int VSYNC_END_X    = 512,
  parameter int ACT_Y0         = 38,
  parameter int ACT_H          = 256
) (
  input  logic [$clog2(LINE_LEN)-1:0]    xCnt,
  input  logic [$clog2(FRAME_LINES)-1:0] yCnt,
  output rasterStrobes_t                 strobes
);
  localparam int X_LAST = LINE_LEN - 1;
  localparam int Y_LAST = FRAME_LINES - 1;
  localparam int Y_END  = ACT_Y0 + ACT_H;

  int xi;
  int yi;

  always_comb begin
    xi = int'(xCnt);
    yi = int'(yCnt);
    strobes.endOfLine  = (xi == X_LAST);
    strobes.endOfFrame = (xi == X_LAST) && (yi == Y_LAST);
    strobes.hsFall     = (xi == 0);
    strobes.hsRise     = (xi == HSYNC_END);
    strobes.vsFall     = (xi == 0) && (yi == 0);
    strobes.vsRise     = (xi == VSYNC_END_X) && (yi == VSYNC_END_LINE);
    // The next line must lie strictly inside the visible band.
    strobes.stepNext   = (xi == X_LAST) && (yi != Y_LAST) &&
                         (yi + 1 > ACT_Y0) && (yi + 1 < Y_END);
  end
endmodule

// File: rtl/raster_dp.sv
module raster_dp
  import raster_pkg::*;
#(
  parameter int LINE_LEN       = 1024,
  parameter int FRAME_LINES    = 312,
  parameter int HSYNC_END      = 75,
  parameter int VSYNC_END_LINE = 2,
  parameter int VSYNC_END_X    = 512,
  parameter int ACT_Y0         = 38,
  parameter int ACT_H          = 256,
  parameter int ACT_X0         = 264,
  parameter int ACT_W          = 640,
  parameter int PREFETCH_LEAD  = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  rasterStrobes_t                 strobes,
  output logic [$clog2(LINE_LEN)-1:0]    xCnt,
  output logic [$clog2(FRAME_LINES)-1:0] yCnt,
  output logic                           hsyncN,
  output logic                           vsyncN,
  output logic                           pixelActive,
  output logic                           prefetchActive,
  output logic                           lineStep
);
  localparam int XW     = $clog2(LINE_LEN);
  localparam int YW     = $clog2(FRAME_LINES);
  localparam int Y_END  = ACT_Y0 + ACT_H;
  localparam int X_END  = ACT_X0 + ACT_W;
  localparam int PF_X0  = ACT_X0 - PREFETCH_LEAD;
  localparam int PF_END = X_END - PREFETCH_LEAD;
  localparam int X_LAST = LINE_LEN - 1;
  localparam int Y_LAST = FRAME_LINES - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      xCnt <= '0;
      yCnt <= '0;
    end else if (strobes.endOfLine) begin
      xCnt <= '0;
      yCnt <= strobes.endOfFrame ? '0 : yCnt + YW'(1);
    end else begin
      xCnt <= xCnt + XW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsyncN   <= 1'b1;
      vsyncN   <= 1'b1;
      lineStep <= 1'b0;
    end else begin
      if (strobes.hsFall)      hsyncN <= 1'b0;
      else if (strobes.hsRise) hsyncN <= 1'b1;
      if (strobes.vsFall)      vsyncN <= 1'b0;
      else if (strobes.vsRise) vsyncN <= 1'b1;
      lineStep <= strobes.stepNext;
    end
  end

  logic visLine;
  always_comb begin
    visLine        = (int'(yCnt) >= ACT_Y0) && (int'(yCnt) < Y_END);
    pixelActive    = visLine && (int'(xCnt) >= ACT_X0) && (int'(xCnt) < X_END);
    prefetchActive = visLine && (int'(xCnt) >= PF_X0) && (int'(xCnt) < PF_END);
  end

  // R2: column steps by one inside a line, line held
  p_x_step_r2: assert property (@(posedge clk) disable iff (rst)
    (int'(xCnt) != X_LAST) |=> (xCnt == $past(xCnt) + XW'(1)) && $stable(yCnt));
  // R2: line advances at the end of a non-final line
  p_line_adv_r2: assert property (@(posedge clk) disable iff (rst)
    (int'(xCnt) == X_LAST && int'(yCnt) != Y_LAST) |=> (xCnt == '0) && (yCnt == $past(yCnt) + YW'(1)));
  // R3: frame wraps to origin
  p_frame_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (int'(xCnt) == X_LAST && int'(yCnt) == Y_LAST) |=> (xCnt == '0) && (yCnt == '0));
  // R4: sync low after column 0, high after the end column
  p_hs_fall_r4: assert property (@(posedge clk) disable iff (rst)
    (xCnt == '0) |=> !hsyncN);
  p_hs_rise_r4: assert property (@(posedge clk) disable iff (rst)
    (int'(xCnt) == HSYNC_END) |=> hsyncN);
  // R5: vertical sync releases mid-line
  p_vs_rise_r5: assert property (@(posedge clk) disable iff (rst)
    (int'(xCnt) == VSYNC_END_X && int'(yCnt) == VSYNC_END_LINE) |=> vsyncN);
  // R7: fetch window is open whenever the visible window opens
  p_pf_lead_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(pixelActive) |-> prefetchActive);
  // R8: line step only at column 0
  p_step_col0_r8: assert property (@(posedge clk) disable iff (rst)
    lineStep |-> (xCnt == '0));
endmodule

// File: rtl/raster_timing.sv
module raster_timing #(
  parameter int LINE_LEN       = 1024,
  parameter int FRAME_LINES    = 312,
  parameter int HSYNC_END      = 75,
  parameter int VSYNC_END_LINE = 2,
  parameter int VSYNC_END_X    = LINE_LEN / 2,
  parameter int ACT_Y0         = 38,
  parameter int ACT_H          = 256,
  parameter int ACT_X0         = 264,
  parameter int ACT_W          = 640,
  parameter int PREFETCH_LEAD  = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  output logic                           hsyncN,
  output logic                           vsyncN,
  output logic [$clog2(LINE_LEN)-1:0]    xPos,
  output logic [$clog2(FRAME_LINES)-1:0] yPos,
  output logic                           pixelActive,
  output logic                           prefetchActive,
  output logic                           lineStep
);
  raster_pkg::rasterStrobes_t strobes;

  raster_ctrl #(
    .LINE_LEN(LINE_LEN), .FRAME_LINES(FRAME_LINES), .HSYNC_END(HSYNC_END),
    .VSYNC_END_LINE(VSYNC_END_LINE), .VSYNC_END_X(VSYNC_END_X),
    .ACT_Y0(ACT_Y0), .ACT_H(ACT_H)
  ) u_ctrl (
    .xCnt(xPos), .yCnt(yPos), .strobes(strobes)
  );

  raster_dp #(
    .LINE_LEN(LINE_LEN), .FRAME_LINES(FRAME_LINES), .HSYNC_END(HSYNC_END),
    .VSYNC_END_LINE(VSYNC_END_LINE), .VSYNC_END_X(VSYNC_END_X),
    .ACT_Y0(ACT_Y0), .ACT_H(ACT_H), .ACT_X0(ACT_X0), .ACT_W(ACT_W),
    .PREFETCH_LEAD(PREFETCH_LEAD)
  ) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .xCnt(xPos), .yCnt(yPos), .hsyncN(hsyncN), .vsyncN(vsyncN),
    .pixelActive(pixelActive), .prefetchActive(prefetchActive), .lineStep(lineStep)
  );
endmodule

// File: tb/raster_timing_bench.sv
module raster_timing_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic       hsD, vsD, actD, preD, stepD;
  logic [9:0] xD;
  logic [8:0] yD;
  logic       hsS, vsS, actS, preS, stepS;
  logic [4:0] xS;
  logic [3:0] yS;

  raster_timing u_raster_timing (
    .clk(clk), .rst(rst), .hsyncN(hsD), .vsyncN(vsD), .xPos(xD), .yPos(yD),
    .pixelActive(actD), .prefetchActive(preD), .lineStep(stepD)
  );

  // Reduced raster: 32 x 10, visible lines 3..6, columns 12..21, fetch 4..13
  raster_timing #(
    .LINE_LEN(32), .FRAME_LINES(10), .HSYNC_END(5), .VSYNC_END_LINE(2),
    .VSYNC_END_X(16), .ACT_Y0(3), .ACT_H(4), .ACT_X0(12), .ACT_W(10),
    .PREFETCH_LEAD(8)
  ) u_raster_timing_small (
    .clk(clk), .rst(rst), .hsyncN(hsS), .vsyncN(vsS), .xPos(xS), .yPos(yS),
    .pixelActive(actS), .prefetchActive(preS), .lineStep(stepS)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct packed {
    int n; int x; int y; bit hs; bit vs; bit act; bit pre; bit step;
  } vec_t;

  // Hand-computed points: cycles after reset release and expected outputs.
  localparam vec_t VEC [19] = '{
    '{0,     0,    0,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1,     1,    0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{75,    75,   0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{76,    76,   0,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1023,  1023, 0,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1024,  0,    1,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{2560,  512,  2,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{2561,  513,  2,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{38188, 300,  37, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{38912, 0,    38, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{39167, 255,  38, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{39168, 256,  38, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    '{39176, 264,  38, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    '{39807, 895,  38, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    '{39808, 896,  38, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    '{39815, 903,  38, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    '{39816, 904,  38, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{39936, 0,    39, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    '{39937, 1,    39, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  typedef struct packed {
    int x; int y; bit hs; bit vs; bit act; bit pre; bit step;
  } exp_t;

  function automatic exp_t model(int n, int l, int f, int he, int vl, int vx,
                                 int y0, int h, int x0, int w, int lead);
    exp_t e;
    int p;
    p = n % (l * f);
    e.x = p % l;
    e.y = p / l;
    e.hs = !(e.x >= 1 && e.x <= he);
    e.vs = !((e.y == 0 && e.x >= 1) || (e.y > 0 && e.y < vl) || (e.y == vl && e.x <= vx));
    e.act = (e.y >= y0 && e.y < y0 + h) && (e.x >= x0 && e.x < x0 + w);
    e.pre = (e.y >= y0 && e.y < y0 + h) && (e.x >= x0 - lead && e.x < x0 + w - lead);
    e.step = (e.x == 0) && (e.y > y0) && (e.y < y0 + h);
    return e;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cmpDefault(input int n);
    exp_t e = model(n, 1024, 312, 75, 2, 512, 38, 256, 264, 640, 8);
    chk("R2", "x", int'(xD), e.x);
    chk("R2", "y", int'(yD), e.y);
    chk("R4", "hsync", int'(hsD), int'(e.hs));
    chk("R5", "vsync", int'(vsD), int'(e.vs));
    chk("R6", "active", int'(actD), int'(e.act));
    chk("R7", "prefetch", int'(preD), int'(e.pre));
    chk("R8", "lineStep", int'(stepD), int'(e.step));
  endtask

  task automatic cmpSmall(input int n);
    exp_t e = model(n, 32, 10, 5, 2, 16, 3, 4, 12, 10, 8);
    chk("R3", "small x", int'(xS), e.x);
    chk("R3", "small y", int'(yS), e.y);
    chk("R4", "small hsync", int'(hsS), int'(e.hs));
    chk("R5", "small vsync", int'(vsS), int'(e.vs));
    chk("R6", "small active", int'(actS), int'(e.act));
    chk("R7", "small prefetch", int'(preS), int'(e.pre));
    chk("R8", "small lineStep", int'(stepS), int'(e.step));
  endtask

  task automatic chkReset(input string tag);
    // R1: idle state
    chk("R1", {tag, " x"}, int'(xD), 0);
    chk("R1", {tag, " y"}, int'(yD), 0);
    chk("R1", {tag, " hsync"}, int'(hsD), 1);
    chk("R1", {tag, " vsync"}, int'(vsD), 1);
    chk("R1", {tag, " lineStep"}, int'(stepD), 0);
    chk("R1", {tag, " small vsync"}, int'(vsS), 1);
  endtask

  initial begin
    int vi = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chkReset("in reset");
    rst = 1'b0;
    for (int n = 0; n <= 40960; n++) begin
      if (n > 0) @(negedge clk);
      if (n == 0) chkReset("first cycle");
      cmpDefault(n);
      cmpSmall(n);
      if (vi < 19 && VEC[vi].n == n) begin
        chk("R2", "table x", int'(xD), VEC[vi].x);
        chk("R2", "table y", int'(yD), VEC[vi].y);
        chk("R4", "table hsync", int'(hsD), int'(VEC[vi].hs));
        chk("R5", "table vsync", int'(vsD), int'(VEC[vi].vs));
        chk("R6", "table active", int'(actD), int'(VEC[vi].act));
        chk("R7", "table prefetch", int'(preD), int'(VEC[vi].pre));
        chk("R8", "table lineStep", int'(stepD), int'(VEC[vi].step));
        vi++;
      end
      // R3: reduced frame ends at (31,9) then returns to origin
      if (n == 319) begin
        chk("R3", "last x", int'(xS), 31);
        chk("R3", "last y", int'(yS), 9);
      end
      if (n == 320) begin
        chk("R3", "wrap x", int'(xS), 0);
        chk("R3", "wrap y", int'(yS), 0);
      end
      // R8: last visible line steps, first line after the band does not
      if (n == 192) chk("R8", "step at last visible line", int'(stepS), 1);
      if (n == 224) chk("R8", "no step past band", int'(stepS), 0);
      if (n == 96)  chk("R8", "no step at first visible line", int'(stepS), 0);
      // R6: bottom visible line edge on reduced raster
      if (n == 6 * 32 + 21) chk("R6", "last visible pixel", int'(actS), 1);
      if (n == 7 * 32 + 12) chk("R6", "below band", int'(actS), 0);
    end
    // R1: reset from mid-frame
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chkReset("mid-frame reset");
    rst = 1'b0;
    cmpDefault(0);
    @(negedge clk);
    cmpDefault(1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule